// File: doc/BRIEF.md
# Serial NOR Flash Transaction Engine

This block is a register-driven SPI master that exists only to issue commands to a serial NOR flash. Software loads a command word (one command byte plus a 24-bit flash address) and a 32-bit data word. It then writes a control word that holds a transmit byte count, a receive byte count and a start bit. The engine runs exactly one chip-select-framed transaction. First it shifts out a fixed byte stream: the command byte, the three address bytes from the most significant down, then the data word from its lowest byte up. After that it clocks in up to four response bytes and places them in the data word. The link is half-duplex: no byte is sent and captured at the same time.

The transaction is controlled by a state machine with five states. ST_IDLE has chip select high and waits for a start. ST_LEAD drives chip select low and waits one SCK half-period. ST_SHIFT toggles SCK and moves the bits. ST_TRAIL keeps chip select low one half-period after the last falling edge. ST_GAP holds chip select high for two half-periods. The transitions are:
- ST_IDLE to ST_LEAD on a start whose effective transmit count is not zero.
- ST_LEAD to ST_SHIFT on the first half-period tick, which also raises SCK.
- ST_SHIFT to ST_TRAIL on the tick that lowers SCK after the final bit.
- ST_TRAIL to ST_GAP on the next tick.
- ST_GAP to ST_IDLE on the second tick.

Busy reads 1 in every state except ST_IDLE.

Top module: `spi_nor_xact`

## Requirements
- R1: The first transmitted byte is command-word bits 7:0. It is followed by command-word bits 31:24, then 23:16, then 15:8. Every byte goes out most significant bit first.
- R2: The control field tx (bits 3:0) sets how many bytes of the stream are sent. Values above 8 act as 8. Exactly 8*(tx+rx) rising SCK edges occur per transaction, using the effective counts.
- R3: Stream bytes 4 to 7 are data-word bytes 0 to 3, in that order, where byte i is bits 8i+7:8i.
- R4: Receive bytes are clocked only after all transmit bytes. The control field rx (bits 6:4) sets their number, and values above 4 act as 4. At completion, received byte i sits in data-word bits 8i+7:8i and every higher byte reads zero. With rx of 0, the data word is left unchanged. MISO levels during transmit bits are never captured.
- R5: SPI mode 0 is used. SCK is low whenever chip select is high. MOSI changes only while SCK is low. MISO is sampled on the rising edge.
- R6: Chip select falls SCK_HALF clocks before the first rising edge. It rises SCK_HALF clocks after the last falling edge. Busy stays 1 for a further 2*SCK_HALF clocks after chip select rises.
- R7: Writing the control word with bit 8 set starts a transaction. Busy (control bit 31) reads 1 from the next clock until completion. Any register write made while busy is ignored, and it starts nothing.
- R8: A start with tx equal to 0 completes at once. Chip select never falls, busy stays 0 and the data word is unchanged.
- R9: Each SCK period lasts 2*SCK_HALF system clocks.
- R10: Register index 0 is the command word and index 1 is the data word. Index 2 is control: it reads busy in bit 31, rx in bits 6:4 and tx in bits 3:0 as last written, and bit 8 reads 0. Index 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| sck | output | 1 | SPI clock, idles low |
| cs_n | output | 1 | Active-low flash chip select |
| mosi | output | 1 | Serial data to the flash |
| miso | input | 1 | Serial data from the flash |

## Verification
Two situations are hard to reach from the ports. The first is a register write that lands while a transaction is still running. The bench reaches it by issuing command, data and control writes a few cycles after a start, while a long eight-byte transmit keeps the engine busy. It then confirms that a single frame was sent with the original bytes and that the registers kept their values. The second is showing that MISO is ignored during transmit bits. For that, the bench's flash model drives MISO high throughout the transmit phase, while random transactions mix the byte counts, including clamped values above the limits.

// File: rtl/spi_nor_pkg.sv
package spi_nor_pkg;

    localparam int WORD_W       = 32;
    localparam int MAX_TX_BYTES = 8;
    localparam int MAX_RX_BYTES = 4;
    localparam int TXN_W        = 4;
    localparam int RXN_W        = 3;
    localparam int BITCNT_W     = 7;

    localparam logic [1:0] RA_CMD  = 2'd0;
    localparam logic [1:0] RA_DATA = 2'd1;
    localparam logic [1:0] RA_CTRL = 2'd2;

    localparam int CF_TX_LSB = 0;
    localparam int CF_RX_LSB = 4;
    localparam int CF_GO     = 8;
    localparam int CF_BUSY   = 31;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_SHIFT,
        ST_TRAIL,
        ST_GAP
    } xact_state_e;

    // Byte k of the outgoing stream: command, address high..low, data low..high.
    function automatic logic [7:0] stream_byte(input logic [WORD_W-1:0] cmd,
                                               input logic [WORD_W-1:0] dat,
                                               input logic [TXN_W-1:0]  idx);
        logic [7:0] b;
        case (idx)
            4'd0:    b = cmd[7:0];
            4'd1:    b = cmd[31:24];
            4'd2:    b = cmd[23:16];
            4'd3:    b = cmd[15:8];
            4'd4:    b = dat[7:0];
            4'd5:    b = dat[15:8];
            4'd6:    b = dat[23:16];
            4'd7:    b = dat[31:24];
            default: b = 8'h00;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/sck_half_timer.sv
module sck_half_timer #(
    parameter int SCK_HALF = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int CW = (SCK_HALF > 1) ? $clog2(SCK_HALF) : 1;

    logic [CW-1:0] cnt_q;

    assign tick = en && (cnt_q == CW'(SCK_HALF - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!en || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    generate
        if (SCK_HALF > 1) begin : g_spacing
            // R9: half-period ticks are never back to back when the divider exceeds one
            p_tick_spacing_r9: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);
        end
    endgenerate

endmodule

// File: rtl/spi_nor_seq.sv
module spi_nor_seq
    import spi_nor_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      go,
    input  logic [TXN_W-1:0]          go_tx,
    input  logic [RXN_W-1:0]          go_rx,
    input  logic [WORD_W-1:0]         cmd_word,
    input  logic [WORD_W-1:0]         data_word,
    input  logic                      tick,
    input  logic                      miso,
    output logic                      run,
    output logic                      busy,
    output logic                      sck,
    output logic                      cs_n,
    output logic                      mosi,
    output logic [WORD_W-1:0]         rx_word,
    output logic                      rx_load
);
    xact_state_e           state_q, state_d;
    logic [TXN_W-1:0]      tx_l;
    logic [RXN_W-1:0]      rx_l;
    logic [BITCNT_W-1:0]   bit_q;
    logic                  sck_q;
    logic                  gap_q;
    logic [WORD_W-1:0]     rxw_q;

    logic [TXN_W-1:0]      nbytes;
    logic [BITCNT_W-1:0]   nbits;
    logic                  last_bit;
    logic [TXN_W-1:0]      byte_idx;
    logic                  in_tx;
    logic [4:0]            rx_off;
    logic [4:0]            rx_pos;
    logic [7:0]            cur_byte;
    logic                  accept;

    assign nbytes   = tx_l + {1'b0, rx_l};
    assign nbits    = {nbytes, 3'b000};
    assign last_bit = (bit_q == nbits - 7'd1);
    assign byte_idx = bit_q[6:3];
    assign in_tx    = byte_idx < tx_l;
    assign rx_off   = bit_q[4:0] - {tx_l[1:0], 3'b000};
    assign rx_pos   = {rx_off[4:3], ~rx_off[2:0]};
    assign cur_byte = stream_byte(cmd_word, data_word, byte_idx);
    assign accept   = go && (state_q == ST_IDLE) && (go_tx != '0);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (accept)                     state_d = ST_LEAD;
            ST_LEAD:  if (tick)                       state_d = ST_SHIFT;
            ST_SHIFT: if (tick && sck_q && last_bit)  state_d = ST_TRAIL;
            ST_TRAIL: if (tick)                       state_d = ST_GAP;
            ST_GAP:   if (tick && gap_q)              state_d = ST_IDLE;
            default:                                  state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        run     = (state_q != ST_IDLE);
        busy    = run;
        cs_n    = !((state_q == ST_LEAD) || (state_q == ST_SHIFT) || (state_q == ST_TRAIL));
        rx_load = (state_q == ST_SHIFT) && tick && sck_q && last_bit && (rx_l != '0);
        mosi    = ((state_q == ST_LEAD) || (state_q == ST_SHIFT)) && in_tx
                  && cur_byte[~bit_q[2:0]];
    end

    assign sck     = sck_q;
    assign rx_word = rxw_q;

    // shifter datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_l  <= '0;
            rx_l  <= '0;
            bit_q <= '0;
            sck_q <= 1'b0;
            gap_q <= 1'b0;
            rxw_q <= '0;
        end else if (accept) begin
            tx_l  <= go_tx;
            rx_l  <= go_rx;
            bit_q <= '0;
            sck_q <= 1'b0;
            gap_q <= 1'b0;
            rxw_q <= '0;
        end else if (tick) begin
            if ((state_q == ST_LEAD) || ((state_q == ST_SHIFT) && !sck_q)) begin
                sck_q <= 1'b1;
                if (!in_tx) rxw_q[rx_pos] <= miso;
            end else if (state_q == ST_SHIFT) begin
                sck_q <= 1'b0;
                if (!last_bit) bit_q <= bit_q + 1'b1;
            end else if (state_q == ST_GAP) begin
                gap_q <= 1'b1;
            end
        end
    end

    // R5: SCK rests low outside a framed transaction
    p_sck_low_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sck_q);
    // R2: the bit counter never passes the requested length while shifting
    p_bit_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SHIFT) |-> (bit_q < nbits));
    // R6: busy persists through the gap after chip select is released
    p_gap_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n) |=> busy);

endmodule

// File: rtl/spi_nor_xact.sv
module spi_nor_xact
    import spi_nor_pkg::*;
#(
    parameter int SCK_HALF = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [1:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              sck,
    output logic              cs_n,
    output logic              mosi,
    input  logic              miso
);
    logic [WORD_W-1:0] cmd_q, data_q;
    logic [TXN_W-1:0]  tx_q;
    logic [RXN_W-1:0]  rx_q;
    logic              busy, run, tick, rx_load, wr_ok, go;
    logic [TXN_W-1:0]  go_tx;
    logic [RXN_W-1:0]  go_rx;
    logic [WORD_W-1:0] rx_word;

    assign wr_ok = bus_we && !busy;
    assign go    = wr_ok && (bus_addr == RA_CTRL) && bus_wdata[CF_GO];
    assign go_tx = (bus_wdata[CF_TX_LSB +: TXN_W] > TXN_W'(MAX_TX_BYTES))
                   ? TXN_W'(MAX_TX_BYTES) : bus_wdata[CF_TX_LSB +: TXN_W];
    assign go_rx = (bus_wdata[CF_RX_LSB +: RXN_W] > RXN_W'(MAX_RX_BYTES))
                   ? RXN_W'(MAX_RX_BYTES) : bus_wdata[CF_RX_LSB +: RXN_W];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q  <= '0;
            data_q <= '0;
            tx_q   <= '0;
            rx_q   <= '0;
        end else begin
            if (rx_load) data_q <= rx_word;
            if (wr_ok) begin
                case (bus_addr)
                    RA_CMD:  cmd_q  <= bus_wdata;
                    RA_DATA: data_q <= bus_wdata;
                    RA_CTRL: begin
                        tx_q <= bus_wdata[CF_TX_LSB +: TXN_W];
                        rx_q <= bus_wdata[CF_RX_LSB +: RXN_W];
                    end
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        case (bus_addr)
            RA_CMD:  bus_rdata = cmd_q;
            RA_DATA: bus_rdata = data_q;
            RA_CTRL: bus_rdata = {busy, 24'd0, rx_q, tx_q};
            default: bus_rdata = '0;
        endcase
    end

    sck_half_timer #(.SCK_HALF(SCK_HALF)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (run),
        .tick  (tick)
    );

    spi_nor_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (go),
        .go_tx     (go_tx),
        .go_rx     (go_rx),
        .cmd_word  (cmd_q),
        .data_word (data_q),
        .tick      (tick),
        .miso      (miso),
        .run       (run),
        .busy      (busy),
        .sck       (sck),
        .cs_n      (cs_n),
        .mosi      (mosi),
        .rx_word   (rx_word),
        .rx_load   (rx_load)
    );

    // R7: writes during a transaction leave the command word untouched
    p_busy_ignore_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && bus_we) |=> $stable(cmd_q));
    // R8: a start with zero transmit bytes never opens a frame
    p_zero_tx_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && bus_we && (bus_addr == RA_CTRL) && bus_wdata[CF_GO]
         && (bus_wdata[3:0] == 4'd0)) |=> (!busy && cs_n));

endmodule

// File: tb/test_spi_nor_xact.sv
`timescale 1ns/1ps
module test_spi_nor_xact;
    localparam int N = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        sck, cs_n, mosi;
    logic        miso = 1'b0;

    always #2.5 clk = ~clk;

    spi_nor_xact #(.SCK_HALF(N)) i_spi_nor_xact (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sck(sck), .cs_n(cs_n),
        .mosi(mosi), .miso(miso)
    );

    int checks = 0, fails = 0, cyc = 0;
    bit finished = 0;
    int frames = 0, rises = 0, viol = 0;
    int cs_fall_c, first_rise_c, second_rise_c, last_fall_c, cs_rise_c;
    logic [127:0] seen;
    logic p_cs = 1'b1, p_sck = 1'b0, p_mosi = 1'b0;
    int cur_tx_eff = 0;
    logic [31:0] cur_resp = '0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic resp_bit(input int k);
        int kb;
        if (k < 8*cur_tx_eff) return 1'b1;
        kb = k - 8*cur_tx_eff;
        if (kb >= 32) return 1'b0;
        return cur_resp[8*(kb/8) + 7 - (kb%8)];
    endfunction

    function automatic logic [7:0] exp_byte(input logic [31:0] c, input logic [31:0] d, input int i);
        if (i == 0) return c[7:0];
        if (i < 4)  return 8'((c >> (8*(4-i))) & 32'hff);
        return 8'((d >> (8*(i-4))) & 32'hff);
    endfunction

    // flash model and link monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (p_cs && !cs_n) begin frames++; cs_fall_c = cyc; rises = 0; end
            if (cs_n && sck) viol++;
            if (p_sck && sck && (mosi != p_mosi)) viol++;
            if (!p_sck && sck) begin
                if (rises == 0) first_rise_c = cyc;
                if (rises == 1) second_rise_c = cyc;
                if (rises < 128) seen[rises] = mosi;
                rises++;
            end
            if (p_sck && !sck) last_fall_c = cyc;
            if (!p_cs && cs_n) cs_rise_c = cyc;
            miso = resp_bit(rises);
        end
        p_cs = cs_n; p_sck = sck; p_mosi = mosi;
    end

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic wait_idle(output int t);
        logic [31:0] r;
        t = 0;
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            bus_read(2'd2, r);
            if (!r[31]) begin t = cyc; return; end
        end
        chk(1'b0, "R7 busy never cleared", 64'd1, 64'd0);
    endtask

    function automatic logic [31:0] ctl_word(input int tx, input int rx);
        logic [31:0] w = '0;
        w[3:0] = 4'(tx);
        w[6:4] = 3'(rx);
        w[8]   = 1'b1;
        return w;
    endfunction

    task automatic run_xact(input logic [31:0] c, input logic [31:0] d, input int tx,
                            input int rx, input logic [31:0] resp, input bit intrude);
        int txe, rxe, f0, t_end;
        logic [31:0] r, expd;
        logic [63:0] act_s, exp_s;
        txe = (tx > 8) ? 8 : tx;
        rxe = (rx > 4) ? 4 : rx;
        cur_tx_eff = txe; cur_resp = resp;
        f0 = frames;
        bus_write(2'd0, c);
        bus_write(2'd1, d);
        bus_write(2'd2, ctl_word(tx, rx));
        bus_read(2'd2, r);
        chk(r[31] == 1'b1, "R7 busy after start", 64'(r[31]), 64'd1);
        chk(r[6:0] == {3'(rx), 4'(tx)}, "R10 control readback", 64'(r[6:0]), 64'({3'(rx), 4'(tx)}));
        if (intrude) begin
            repeat (3) @(negedge clk);
            bus_write(2'd0, ~c);
            bus_write(2'd1, ~d);
            bus_write(2'd2, ctl_word(2, 1));
        end
        wait_idle(t_end);
        chk(frames == f0 + 1, "R7 one frame per start", 64'(frames - f0), 64'd1);
        chk(rises == 8*(txe+rxe), "R2 rising edge count", 64'(rises), 64'(8*(txe+rxe)));
        act_s = '0; exp_s = '0;
        for (int k = 0; k < 8*txe; k++) begin
            act_s[63-k] = seen[k];
            exp_s[63-k] = exp_byte(c, d, k/8)[7 - (k%8)];
        end
        chk(act_s[63:32] == exp_s[63:32], "R1 command and address bytes", act_s[63:32], exp_s[63:32]);
        chk(act_s[31:0] == exp_s[31:0], "R3 data bytes", act_s[31:0], exp_s[31:0]);
        chk(first_rise_c - cs_fall_c == N, "R6 lead time", 64'(first_rise_c - cs_fall_c), 64'(N));
        chk(cs_rise_c - last_fall_c == N, "R6 trail time", 64'(cs_rise_c - last_fall_c), 64'(N));
        chk(t_end - cs_rise_c == 2*N, "R6 gap time", 64'(t_end - cs_rise_c), 64'(2*N));
        if (rises >= 2)
            chk(second_rise_c - first_rise_c == 2*N, "R9 SCK period",
                64'(second_rise_c - first_rise_c), 64'(2*N));
        expd = '0;
        if (rxe == 0) expd = d;
        for (int j = 0; j < rxe; j++) expd[8*j +: 8] = resp[8*j +: 8];
        bus_read(2'd1, r);
        chk(r == expd, "R4 received data word", 64'(r), 64'(expd));
        if (intrude) begin
            bus_read(2'd0, r);
            chk(r == c, "R7 command ignored while busy", 64'(r), 64'(c));
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++; checks++;
            $display("FAIL watchdog act=0 exp=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] r, d0;
        int f0;
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cs_n == 1'b1, "R5 reset chip select", 64'(cs_n), 64'd1);
        chk(sck == 1'b0, "R5 reset SCK", 64'(sck), 64'd0);
        bus_read(2'd2, r);
        chk(r == 32'd0, "R10 reset control", 64'(r), 64'd0);
        bus_read(2'd3, r);
        chk(r == 32'd0, "R10 unused index", 64'(r), 64'd0);

        // directed: full eight-byte write with receive, then clamped counts
        run_xact(32'hA1B2C3D4, 32'h11223344, 8, 4, 32'h5A6B7C8D, 1'b0);
        run_xact(32'h00FF0003, 32'hCAFEF00D, 12, 6, 32'h89ABCDEF, 1'b0);
        run_xact(32'h0000009F, 32'hFFFFFFFF, 1, 3, 32'h00C2201A, 1'b0);
        run_xact(32'h00000005, 32'h76543210, 1, 0, 32'h0, 1'b0);
        // directed: writes while busy
        run_xact(32'h12345602, 32'hDEADBEEF, 8, 0, 32'h0, 1'b1);

        // directed: zero transmit count
        bus_write(2'd1, 32'h0BADCAFE);
        f0 = frames;
        bus_write(2'd2, ctl_word(0, 3));
        bus_read(2'd2, r);
        chk(r[31] == 1'b0, "R8 zero tx not busy", 64'(r[31]), 64'd0);
        repeat (20) @(negedge clk);
        chk(frames == f0, "R8 zero tx no frame", 64'(frames - f0), 64'd0);
        bus_read(2'd1, d0);
        chk(d0 == 32'h0BADCAFE, "R8 zero tx data kept", 64'(d0), 64'h0BADCAFE);

        for (int n = 0; n < 30; n++) begin
            run_xact($urandom, $urandom, int'($urandom_range(1, 10)),
                     int'($urandom_range(0, 7)), $urandom, 1'b0);
        end

        chk(viol == 0, "R5 mode-0 SCK/MOSI discipline", 64'(viol), 64'd0);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule